// File: doc/BRIEF.md
# Centre-Aligned PWM Channel with Fractional Edge Dithering

This block produces one centre-aligned PWM output from its own up/down counter. The counter climbs from a programmable start value to a programmable top value, then falls back to the start value, and repeats. The output is active in the part of each cycle where the counter is below a compare threshold. That gives a pulse centred on the bottom of the count, with a width of twice the distance between the compare value and the start value.

To get a finer average duty than one counter step, a 5-bit fraction is added to an internal accumulator once per PWM period. In a period where that addition wraps past 32, both pulse edges move outwards by one counter step. That period's pulse is then two units wider. Over 32 periods, the average width rises by 2·fraction/32 units. A polarity input chooses high-true or low-true output.

The PWM period runs from one top turnaround to the next. The whole pulse therefore lies inside one period, and both of its edges follow the same dither decision.

Top module: `cpwm_dither`

## Requirements
- R1: While `rst` is high at a clock edge, the counter loads `init_val` with direction up, the accumulator and the dither flag clear, and `pwm_o` takes its inactive level. The inactive level is 0 when `pol_high`=1 and 1 when `pol_high`=0.
- R2: The counter direction is shown on `cnt_down` (1 = counting down). Counting up, the counter steps +1 each cycle until it reaches `mod_val`. In that top-turnaround cycle, `cnt_down` becomes 1 and the counter steps −1. Counting down, it steps −1 until it reaches `init_val`. In that bottom-turnaround cycle, `cnt_down` becomes 0 and the counter steps +1. One period lasts 2·(mod−init) cycles.
- R3: On every top turnaround, the 5-bit accumulator takes acc+frac. A sum of 32 or more sets the dither flag for the following period and keeps sum−32. A smaller sum clears the flag.
- R4: The compare level is cmp+flag. The output is active in a counter state if that level exceeds `init_val` and one of these holds: the counter is counting down or sits at the top, and the counter is at or below the level; or the counter is counting up below the top, and the counter is below the level. `pwm_o` in cycle t shows the state of cycle t−1. An undithered period therefore gives 2·(cmp−init) active cycles.
- R5: In a dithered period, the first edge happens when the counter passes cmp+1 going down, and the last edge when it reaches cmp+1 going up. The width is 2·(cmp−init+1).
- R6: With `frac_val`=0, the flag is never set and every pulse uses the plain compare edges.
- R7: With `pol_high`=0, the output is the inverse of the high-true output.
- R8: With `cmp_val` ≥ `mod_val`, the output stays active at all times. With `cmp_val` ≤ `init_val` and no dither, it never becomes active.
- R9: From reset with init=0, mod=6, cmp=3, frac=3 and `pol_high`=1, the high pulse widths are 3 (a partial pulse), then ten pulses of 6, then one of 8 (the 11th addition wraps to 0x01), then 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_val | input | CW | Counter start (bottom) value |
| mod_val | input | CW | Counter top value |
| cmp_val | input | CW | Compare threshold |
| frac_val | input | FW | Fraction added per period |
| pol_high | input | 1 | 1 = high-true output, 0 = low-true |
| cnt_o | output | CW | Counter value |
| cnt_down | output | 1 | 1 while counting down |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The dithered period is the hardest case to reach. It needs the accumulator to wrap. A small fraction only wraps after many periods, and the single wide pulse then has to be caught exactly. The directed example runs twelve full periods from reset and measures every pulse width. Random phases with a fixed seed pick large fractions and short periods, so wraps happen often. They also change the settings mid-count, including while the counter sits outside the new range. A cycle-exact bench model covers every cycle of these phases.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int unsigned CPWM_CW = 16;
  localparam int unsigned CPWM_FW = 5;
endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] init_val,
  input  logic [CW-1:0] mod_val,
  output logic [CW-1:0] cnt,
  output logic          down,
  output logic          at_top
);
  logic at_bot;

  assign at_top = !down && (cnt >= mod_val);
  assign at_bot = down && (cnt <= init_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= init_val;
      down <= 1'b0;
    end else if (at_top) begin
      down <= 1'b1;
      cnt  <= (cnt > init_val) ? cnt - 1'b1 : cnt;
    end else if (at_bot) begin
      down <= 1'b0;
      cnt  <= (cnt < mod_val) ? cnt + 1'b1 : cnt;
    end else if (down) begin
      cnt <= cnt - 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_TOP_TURNS: assert property (@(posedge clk) disable iff (rst)
    (!down && cnt == mod_val && mod_val > init_val) |=> down); // R2
  AST_BOT_TURNS: assert property (@(posedge clk) disable iff (rst)
    (down && cnt == init_val && mod_val > init_val) |=> !down); // R2
endmodule

// File: rtl/cpwm_frac_acc.sv
module cpwm_frac_acc #(
  parameter int unsigned FW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [FW-1:0] frac,
  output logic          dither
);
  logic [FW-1:0] acc;
  logic [FW:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, frac};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      dither <= 1'b0;
    end else if (step) begin
      acc    <= sum[FW-1:0];
      dither <= sum[FW];
    end
  end

  AST_HOLD_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(acc) && $stable(dither))); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (step && frac == '0) |=> !dither); // R6
endmodule

// File: rtl/cpwm_edge.sv
module cpwm_edge #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic          down,
  input  logic          at_top,
  input  logic          dither,
  input  logic [CW-1:0] init_val,
  input  logic [CW-1:0] cmp_val,
  input  logic          pol_high,
  output logic          pwm_o
);
  localparam int unsigned EW = CW + 1;

  logic [EW-1:0] level;
  logic [EW-1:0] cnt_x;
  logic          falling_side;
  logic          active;

  assign level        = {1'b0, cmp_val} + EW'(dither);
  assign cnt_x        = {1'b0, cnt};
  assign falling_side = down || at_top;
  assign active       = (level > {1'b0, init_val}) &&
                        (falling_side ? (cnt_x <= level) : (cnt_x < level));

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= !pol_high;
    else     pwm_o <= pol_high ? active : !active;
  end

  AST_IDLE_WHEN_LOW_CMP: assert property (@(posedge clk) disable iff (rst)
    (cmp_val <= init_val && !dither) |=> (pwm_o == !$past(pol_high))); // R8
  AST_FULL_WHEN_HIGH_CMP: assert property (@(posedge clk) disable iff (rst)
    (cmp_val >= cnt && cmp_val > init_val && (down || at_top)) |=> (pwm_o == $past(pol_high))); // R4
endmodule

// File: rtl/cpwm_dither.sv
module cpwm_dither
  import cpwm_pkg::*;
#(
  parameter int unsigned CW = CPWM_CW,
  parameter int unsigned FW = CPWM_FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] init_val,
  input  logic [CW-1:0] mod_val,
  input  logic [CW-1:0] cmp_val,
  input  logic [FW-1:0] frac_val,
  input  logic          pol_high,
  output logic [CW-1:0] cnt_o,
  output logic          cnt_down,
  output logic          pwm_o
);
  logic at_top;
  logic dither;

  cpwm_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .init_val(init_val), .mod_val(mod_val),
    .cnt(cnt_o), .down(cnt_down), .at_top(at_top)
  );

  cpwm_frac_acc #(.FW(FW)) u_acc (
    .clk(clk), .rst(rst), .step(at_top), .frac(frac_val), .dither(dither)
  );

  cpwm_edge #(.CW(CW)) u_edge (
    .clk(clk), .rst(rst), .cnt(cnt_o), .down(cnt_down), .at_top(at_top),
    .dither(dither), .init_val(init_val), .cmp_val(cmp_val),
    .pol_high(pol_high), .pwm_o(pwm_o)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!cnt_down && pwm_o == !$past(pol_high))); // R1
endmodule

// File: tb/test_cpwm_dither.sv
`timescale 1ns/1ps
module test_cpwm_dither;
  localparam int CW = 16;
  localparam int FW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] init_val = '0;
  logic [CW-1:0] mod_val = 16'd6;
  logic [CW-1:0] cmp_val = 16'd3;
  logic [FW-1:0] frac_val = 5'd3;
  logic          pol_high = 1'b1;
  logic [CW-1:0] cnt_o;
  logic          cnt_down;
  logic          pwm_o;

  int n_run = 0;
  int n_fail = 0;

  int  m_cnt;
  bit  m_down;
  int  m_acc;
  bit  m_ov;
  bit  m_pwm;

  bit  measure = 1'b0;
  int  run_len = 0;
  int  widths[0:31];
  int  n_w = 0;

  always #4 clk = ~clk;

  cpwm_dither i_cpwm_dither (
    .clk(clk), .rst(rst), .init_val(init_val), .mod_val(mod_val),
    .cmp_val(cmp_val), .frac_val(frac_val), .pol_high(pol_high),
    .cnt_o(cnt_o), .cnt_down(cnt_down), .pwm_o(pwm_o)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit ref_active(int cnt, bit down, bit ov, int init, int mo, int cmp);
    int lvl = cmp + (ov ? 1 : 0);
    bit fall = down || (cnt >= mo);
    if (lvl <= init) return 1'b0;
    return fall ? (cnt <= lvl) : (cnt < lvl);
  endfunction

  task automatic model_reset();
    m_cnt = int'(init_val); m_down = 1'b0; m_acc = 0; m_ov = 1'b0; m_pwm = !pol_high;
  endtask

  task automatic model_step();
    int init = int'(init_val);
    int mo   = int'(mod_val);
    bit top  = !m_down && (m_cnt >= mo);
    bit bot  = m_down && (m_cnt <= init);
    bit act  = ref_active(m_cnt, m_down, m_ov, init, mo, int'(cmp_val));
    m_pwm = pol_high ? act : !act;
    if (top) begin
      int s = m_acc + int'(frac_val);
      m_ov  = (s >= 32);
      m_acc = s % 32;
      m_down = 1'b1;
      if (m_cnt > init) m_cnt--;
    end else if (bot) begin
      m_down = 1'b0;
      if (m_cnt < mo) m_cnt++;
    end else if (m_down) m_cnt--;
    else m_cnt++;
  endtask

  task automatic cyc(string tag);
    model_step();
    @(negedge clk);
    check(int'(cnt_o) == m_cnt, {tag, " counter (R2)"}, int'(cnt_o), m_cnt);
    check(cnt_down == m_down, {tag, " direction (R2)"}, cnt_down, m_down);
    check(pwm_o == m_pwm, {tag, " output"}, pwm_o, m_pwm);
    if (measure) begin
      if (pwm_o) run_len++;
      else if (run_len > 0) begin
        if (n_w < 32) widths[n_w] = run_len;
        n_w++;
        run_len = 0;
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    model_reset();
    check(int'(cnt_o) == int'(init_val), "R1 reset counter", int'(cnt_o), int'(init_val));
    check(cnt_down == 1'b0, "R1 reset direction", cnt_down, 0);
    check(pwm_o == !pol_high, "R1 reset output inactive", pwm_o, !pol_high);
    rst = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int exp_w[0:12];
    // R9 directed example, R3 wrap on the 11th addition, R4/R5 widths
    do_reset();
    measure = 1'b1;
    for (int i = 0; i < 12 * 12 + 6; i++) cyc("R9");
    measure = 1'b0;
    exp_w[0] = 3;
    for (int i = 1; i <= 10; i++) exp_w[i] = 6;
    exp_w[11] = 8;
    exp_w[12] = 6;
    check(n_w >= 13, "R9 pulse count", n_w, 13);
    for (int i = 0; i < 13; i++) begin
      if (i == 11) check(widths[i] == exp_w[i], "R5 dithered width", widths[i], exp_w[i]);
      else check(widths[i] == exp_w[i], "R4 plain width", widths[i], exp_w[i]);
    end

    // R6 zero fraction: no dithering
    frac_val = 5'd0; init_val = 16'd2; mod_val = 16'd20; cmp_val = 16'd9;
    do_reset();
    measure = 1'b1; n_w = 0; run_len = 0;
    for (int i = 0; i < 36 * 8; i++) cyc("R6");
    measure = 1'b0;
    for (int i = 1; i < 7; i++) check(widths[i] == 14, "R6 constant width", widths[i], 14);

    // R7 low-true output with dithering
    pol_high = 1'b0; frac_val = 5'd17;
    do_reset();
    for (int i = 0; i < 400; i++) cyc("R7");

    // R8 compare at/above top: always active; at/below bottom: never
    pol_high = 1'b1; frac_val = 5'd0; cmp_val = 16'd20;
    do_reset();
    for (int i = 0; i < 80; i++) begin
      cyc("R8 full");
      check(pwm_o == 1'b1, "R8 full active", pwm_o, 1);
    end
    cmp_val = 16'd2;
    do_reset();
    for (int i = 0; i < 80; i++) begin
      cyc("R8 none");
      check(pwm_o == 1'b0, "R8 never active", pwm_o, 0);
    end

    // R3/R5 random phases with a fixed seed, settings changed mid-count
    void'($urandom(32'h5eed_c0de));
    for (int ph = 0; ph < 40; ph++) begin
      int len;
      init_val = 16'($urandom_range(0, 12));
      mod_val  = init_val + 16'($urandom_range(1, 24));
      cmp_val  = 16'($urandom_range(0, int'(mod_val) + 3));
      frac_val = 5'($urandom_range(0, 31));
      pol_high = 1'($urandom_range(0, 1));
      len = $urandom_range(40, 300);
      for (int i = 0; i < len; i++) cyc("R3 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule